// File: doc/BRIEF.md
# Serial Control Port with Selectable Frame Length

This block is a serial slave that lets a host exchange fixed-width command and status words over four lines: an active-low select, a serial clock, a data input and a data output. The serial pins are brought into the system clock domain through two-stage synchronizers. Rising serial-clock edges are then detected on the system clock, so the block has a single clock and a host clock much slower than the system clock is assumed.

Two framing modes are selectable. In the long mode a frame has 16 rising edges while selected. In the short mode a frame has 15 rising edges while selected, plus exactly one further edge after deselect. That further edge supplies the last input bit and, in the same cycle, loads the next outgoing word. A completed frame is decoded into write, read and interrupt-request actions on a parallel register port. The word returned in the following frame carries one of three payloads: read data, the interrupt register contents, or the normal status byte. It also carries a conversion-done flag and a frame-error flag.

Top module: `sctl_serial_port`

## Requirements
- R1: Long mode (`frame_15_i`=0). Data in is shifted in most significant bit first on each rising serial-clock edge while `cs_n_i` is low. When `cs_n_i` rises after exactly 16 edges, the word is committed. Command layout: bit 15 = write, bit 14 = read, bit 13 = interrupt request, bits 12:8 = address, bits 7:0 = write data. A write command gives a single-cycle `reg_we_o` pulse with `reg_addr_o` and `reg_wdata_o`.
- R2: Short mode (`frame_15_i`=1). A frame is 15 edges while selected, followed by one edge while deselected. That last edge supplies bit 0 and commits the word. The response for the next frame is loaded in the same step.
- R3: Response layout: bit 15 = conversion done, bit 14 = frame error, bit 13 = interrupt payload, bits 12:8 = zero, bits 7:0 = payload. Bit 15 appears on `miso_o` once the frame is selected. Each rising edge while selected advances to the next lower bit.
- R4: A read command gives a single-cycle `reg_re_o` pulse. The `reg_rdata_i` value present in that cycle is the payload of the next frame. With no read and no interrupt request, the payload is `status_i`.
- R5: A committed frame with the interrupt-request bit set makes the immediately following frame return `irq_reg_i` with bit 13 set. This takes precedence over read data. The redirection covers only that one frame.
- R6: A `conv_done_i` pulse since the previous response load sets bit 15 in the next loaded response. The flag clears after being loaded once. Several pulses before one load give a single flag.
- R7: A frame whose edge count is wrong for the selected mode gives no register strobe. The next response has bit 14 set and the `status_i` payload. In short mode, a frame that lacks the edge after deselect is flagged when select falls again, and that frame returns the error word.
- R8: An all-zero command gives no strobe and returns the `status_i` payload.
- R9: Rising edges while deselected have no effect, apart from the single completing edge of short mode.
- R10: `miso_oe_o` is low while deselected and high while selected.
- R11: After reset, `miso_oe_o`, `reg_we_o` and `reg_re_o` are low, and the first frame returns an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_15_i | input | 1 | 1 selects the 15+1 edge frame, 0 the 16 edge frame |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| conv_done_i | input | 1 | Conversion-complete event pulse |
| status_i | input | DATA_W | Normal status payload |
| irq_reg_i | input | DATA_W | Interrupt register payload |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data, valid in the `reg_re_o` cycle |

## Verification
The bench builds the block with its defaults, ADDR_W=5 and DATA_W=8. With these values all 32 register addresses can be written and read back in both frame modes, with every read result checked in the response of the following frame. The same small configuration keeps each frame to 16 bits. That makes it cheap to drive edge counts of 15, 16 and 17, short frames that lack the completing edge, and extra deselected edges, each followed by a check of the error flag, the interrupt redirection and the done flag.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_ACTIVE = 2'd1,
    FR_TAIL   = 2'd2
  } fr_state_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/sctl_framer.sv
module sctl_framer
  import sctl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame15_i,
  input  logic         cs_n_i,
  input  logic         sclk_i,
  input  logic         mosi_i,
  output logic         shift_o,
  output logic         ok_o,
  output logic         err_o,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W + 2);

  fr_state_e      st;
  logic           sclk_q;
  logic           sclk_rise;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign sclk_rise = sclk_i & ~sclk_q;
  assign shift_o   = (st == FR_ACTIVE) & ~cs_n_i & sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= FR_IDLE;
      cnt    <= '0;
      rx     <= '0;
      word_o <= '0;
      ok_o   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
      case (st)
        FR_IDLE: begin
          if (!cs_n_i) begin
            st  <= FR_ACTIVE;
            cnt <= '0;
          end
        end
        FR_ACTIVE: begin
          if (cs_n_i) begin
            st <= FR_IDLE;
            if (frame15_i && cnt == CW'(W - 1)) begin
              st <= FR_TAIL;
            end else if (!frame15_i && cnt == CW'(W)) begin
              ok_o   <= 1'b1;
              word_o <= rx;
            end else begin
              err_o <= 1'b1;
            end
          end else if (sclk_rise) begin
            rx <= {rx[W-2:0], mosi_i};
            if (cnt != CW'(W + 1)) cnt <= cnt + 1'b1;
          end
        end
        FR_TAIL: begin
          // reselect without the completing edge: frame lost
          if (!cs_n_i) begin
            st    <= FR_ACTIVE;
            cnt   <= '0;
            err_o <= 1'b1;
          end else if (sclk_rise) begin
            word_o <= {rx[W-2:0], mosi_i};
            ok_o   <= 1'b1;
            st     <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sctl_resp.sv
module sctl_resp #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int W      = 3 + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ok_i,
  input  logic              err_i,
  input  logic              shift_i,
  input  logic [W-1:0]      word_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] irq_reg_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sdo_o
);
  logic              cmd_wr, cmd_rd, cmd_irq;
  logic              irq_sel;
  logic              load;
  logic              done_pend;
  logic [DATA_W-1:0] payload;
  logic [W-1:0]      tx_q;
  logic [W-1:0]      tx_nxt;

  assign cmd_wr  = word_i[W-1];
  assign cmd_rd  = word_i[W-2];
  assign cmd_irq = word_i[W-3];
  assign addr_o  = word_i[DATA_W +: ADDR_W];
  assign wdata_o = word_i[DATA_W-1:0];

  assign we_o    = ok_i & cmd_wr;
  assign re_o    = ok_i & cmd_rd;
  assign irq_sel = ok_i & cmd_irq;
  assign load    = ok_i | err_i;

  always_comb begin
    if (irq_sel)          payload = irq_reg_i;
    else if (ok_i && cmd_rd) payload = rdata_i;
    else                  payload = status_i;
  end

  assign tx_nxt = {done_pend | conv_done_i, err_i, irq_sel, {ADDR_W{1'b0}}, payload};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      done_pend <= 1'b0;
    end else if (load) begin
      tx_q      <= tx_nxt;
      done_pend <= 1'b0;
    end else begin
      if (shift_i)     tx_q <= {tx_q[W-2:0], 1'b0};
      if (conv_done_i) done_pend <= 1'b1;
    end
  end

  assign sdo_o = tx_q[W-1];
endmodule

// File: rtl/sctl_serial_port.sv
module sctl_serial_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_15_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] irq_reg_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int W = 3 + ADDR_W + DATA_W;

  logic [2:0]   pins_s;
  logic         shift;
  logic         frame_ok;
  logic         frame_err;
  logic [W-1:0] word;

  sctl_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_n_i, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  sctl_framer #(.W(W)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame15_i(frame_15_i),
    .cs_n_i   (pins_s[2]),
    .sclk_i   (pins_s[1]),
    .mosi_i   (pins_s[0]),
    .shift_o  (shift),
    .ok_o     (frame_ok),
    .err_o    (frame_err),
    .word_o   (word)
  );

  sctl_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(W)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ok_i       (frame_ok),
    .err_i      (frame_err),
    .shift_i    (shift),
    .word_i     (word),
    .conv_done_i(conv_done_i),
    .status_i   (status_i),
    .irq_reg_i  (irq_reg_i),
    .rdata_i    (reg_rdata_i),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .sdo_o      (miso_o)
  );

  assign miso_oe_o = ~pins_s[2];
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic sclk_i,
  input logic miso_o,
  input logic miso_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic frame_err_i
);
  logic       sclk_p, cs_p;
  logic [2:0] quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
      quiet  <= '0;
    end else begin
      sclk_p <= sclk_i;
      cs_p   <= cs_n_i;
      if (sclk_i != sclk_p || cs_n_i != cs_p) quiet <= '0;
      else if (quiet != 3'd7)                 quiet <= quiet + 1'b1;
    end
  end

  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) |-> !miso_oe_o);

  // R3
  miso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet >= 3'd5 |-> $stable(miso_o));

  // R1
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R4
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R1
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> !miso_oe_o);

  // R7
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_i |-> !reg_we_o && !reg_re_o);
endmodule

bind sctl_serial_port sctl_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .sclk_i     (sclk_i),
  .miso_o     (miso_o),
  .miso_oe_o  (miso_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .frame_err_i(frame_err)
);

// File: tb/sctl_serial_port_tb.sv
module sctl_serial_port_tb;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          frame15 = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic          conv_done = 1'b0;
  logic [DW-1:0] status_v = '0, irq_v = 8'hC3;
  logic          miso, miso_oe, reg_we, reg_re;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  sctl_serial_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_15_i(frame15), .cs_n_i(cs_n),
    .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe),
    .conv_done_i(conv_done), .status_i(status_v), .irq_reg_i(irq_v),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  // register file seen by the port
  logic [DW-1:0] regs [32];
  int wr_cnt, rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= '0;
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_we) begin
        regs[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_re) rd_cnt <= rd_cnt + 1;
    end
  end
  assign reg_rdata = regs[reg_addr];

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] mdl [32];
  logic [15:0] exp_resp = '0;
  logic done_seen = 1'b0, tail_pend = 1'b0;
  int exp_wr = 0, exp_rd = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic d, logic e, logic q, logic [7:0] p);
    return {d, e, q, 5'b0, p};
  endfunction

  task automatic pulse_done();
    @(negedge clk) conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    done_seen = 1'b1;
  endtask

  task automatic idle_edges(input int n);
    mosi = 1'b1;
    for (int j = 0; j < n; j++) begin
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
    end
    mosi = 1'b0;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic run_frame(input string tag, input logic [15:0] cmd, input int n_low, input int n_high);
    logic [15:0] got;
    logic ok, err, d;
    got = '0;
    if (tail_pend) begin
      exp_resp  = mk(done_seen, 1'b1, 1'b0, status_v);
      done_seen = 1'b0;
      tail_pend = 1'b0;
    end
    @(negedge clk) cs_n = 1'b0;
    repeat (2 * HP) @(negedge clk);
    chk("R10 oe selected", {31'b0, miso_oe}, 32'd1);
    for (int i = 0; i < n_low; i++) begin
      mosi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    if (n_low == 15) begin
      repeat (HP) @(negedge clk);
      got[0] = miso;
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    for (int j = 0; j < n_high; j++) begin
      mosi = (n_low + j < 16) ? cmd[15-n_low-j] : 1'b0;
      repeat (HP) @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
    end
    mosi = 1'b0;
    repeat (3 * HP) @(negedge clk);
    chk("R10 oe deselected", {31'b0, miso_oe}, 32'd0);
    if (n_low >= 15) chk({tag, " R3 response"}, {16'b0, got}, {16'b0, exp_resp});
    ok  = frame15 ? (n_low == 15 && n_high >= 1) : (n_low == 16);
    err = !ok && !(frame15 && n_low == 15 && n_high == 0);
    if (!ok && !err) begin
      tail_pend = 1'b1;
    end else begin
      d = done_seen;
      done_seen = 1'b0;
      if (err)          exp_resp = mk(d, 1'b1, 1'b0, status_v);
      else if (cmd[13]) exp_resp = mk(d, 1'b0, 1'b1, irq_v);
      else if (cmd[14]) exp_resp = mk(d, 1'b0, 1'b0, mdl[cmd[12:8]]);
      else              exp_resp = mk(d, 1'b0, 1'b0, status_v);
      if (ok && cmd[15]) begin
        mdl[cmd[12:8]] = cmd[7:0];
        exp_wr++;
      end
      if (ok && cmd[14]) exp_rd++;
    end
    chk({tag, " write count"}, wr_cnt, exp_wr);
    chk({tag, " read count"}, rd_cnt, exp_rd);
    if (ok && cmd[15]) chk({tag, " written value"}, {24'b0, regs[cmd[12:8]]}, {24'b0, cmd[7:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 oe", {31'b0, miso_oe}, 32'd0);
    chk("R11 we", {31'b0, reg_we}, 32'd0);
    chk("R11 re", {31'b0, reg_re}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    status_v = 8'h11;
    run_frame("R11 first frame R8", 16'h0000, 16, 0);

    // R1 long-mode sweep, R4 read back
    for (int a = 0; a < 32; a++) begin
      status_v = 8'h80 + 8'(a);
      run_frame("R1", {3'b100, 5'(a), 8'((a * 37 + 11) % 256)}, 16, 0);
      run_frame("R4", {3'b010, 5'(a), 8'h00}, 16, 0);
    end
    run_frame("R4 R8", 16'h0000, 16, 0);

    // R2 short-mode sweep
    frame15 = 1'b1;
    for (int a = 0; a < 32; a++) begin
      status_v = 8'h40 ^ 8'(a);
      run_frame("R2", {3'b100, 5'(a), 8'((a * 91 + 3) % 256)}, 15, 1);
      run_frame("R2 R4", {3'b010, 5'(a), 8'h00}, 15, 1);
    end
    run_frame("R2 R8", 16'h0000, 15, 1);

    // R5 interrupt redirection, both modes, precedence over read
    for (int m = 0; m < 2; m++) begin
      frame15 = m[0];
      irq_v = m[0] ? 8'h96 : 8'hC3;
      run_frame("R5 request", {3'b001, 5'd0, 8'h00}, m[0] ? 15 : 16, m[0] ? 1 : 0);
      run_frame("R5 redirected", 16'h0000, m[0] ? 15 : 16, m[0] ? 1 : 0);
      run_frame("R5 one frame only", {3'b011, 5'd3, 8'h00}, m[0] ? 15 : 16, m[0] ? 1 : 0);
      run_frame("R5 over read", 16'h0000, m[0] ? 15 : 16, m[0] ? 1 : 0);
      run_frame("R5 back to status", 16'h0000, m[0] ? 15 : 16, m[0] ? 1 : 0);
    end

    // R6 done flag
    frame15 = 1'b0;
    pulse_done();
    run_frame("R6 load", 16'h0000, 16, 0);
    run_frame("R6 flag", 16'h0000, 16, 0);
    pulse_done();
    pulse_done();
    run_frame("R6 cleared", 16'h0000, 16, 0);
    frame15 = 1'b1;
    run_frame("R6 merged", 16'h0000, 15, 1);
    run_frame("R6 short mode", 16'h0000, 15, 1);

    // R7 bad edge counts
    frame15 = 1'b0;
    status_v = 8'h3A;
    run_frame("R7 short long-frame", {3'b100, 5'd7, 8'hEE}, 15, 0);
    run_frame("R7 error word", 16'h0000, 17, 0);
    run_frame("R7 error again", 16'h0000, 16, 0);
    frame15 = 1'b1;
    run_frame("R7 sixteen in short mode", {3'b100, 5'd9, 8'hDD}, 16, 1);
    run_frame("R7 flagged", 16'h0000, 15, 1);
    run_frame("R7 missing tail", {3'b100, 5'd10, 8'hBB}, 15, 0);
    run_frame("R7 tail error word", 16'h0000, 15, 1);
    run_frame("R7 recovered", 16'h0000, 15, 1);

    // R9 deselected edges
    run_frame("R9 extra tail edges", {3'b100, 5'd12, 8'h5C}, 15, 3);
    idle_edges(5);
    run_frame("R9 short mode idle", {3'b010, 5'd12, 8'h00}, 15, 1);
    frame15 = 1'b0;
    run_frame("R9 long extra", {3'b100, 5'd13, 8'hA7}, 16, 2);
    idle_edges(4);
    run_frame("R9 long idle", {3'b010, 5'd13, 8'h00}, 16, 0);
    run_frame("R9 R8 final", 16'h0000, 16, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule